// File: doc/BRIEF.md
# Interrupt Acknowledge Autovector Terminator

This block ends external interrupt-acknowledge bus cycles and reports which vector number the processor should use. During such a cycle, a device can ask for an autovector in two ways: through an active-high request pin, or through an internal request from chip-select decoding. In that case the block generates the vector number itself from the acknowledged interrupt level. If no autovector is requested, the device ends the cycle with a normal data acknowledge. The vector number is then taken from the low byte of the data bus.

The result leaves on a plain one-cycle `vec_valid` strobe together with `is_auto` and `vector`. There is no back-pressure, because a bus cycle that has been ended cannot be held off, so the consumer must take the result in the cycle `vec_valid` is high. `vector` and `is_auto` keep their values until the next termination. While an external master owns the bus, the block terminates nothing. Any other bus cycle type passes through untouched.

Top module: `iack_vec_term`

## Requirements
- R1: After reset, `vec_valid` is 0, `is_auto` is 0 and `vector` is 0.
- R2: An interrupt-acknowledge cycle is one where `cyc_active` is 1 and `cyc_type` is 2'b11. If `avec_pin` is 1 at a clock edge during such a cycle, and `ext_master` is 0, then after that edge `vec_valid` is 1 for one cycle, `is_auto` is 1 and `vector` is 24 plus `ack_level`. Levels 1 to 7 give 25 to 31.
- R3: The internal request `cs_avec` has exactly the same effect as `avec_pin`.
- R4: If no autovector request is present and `data_ack` is 1 at an edge during an interrupt-acknowledge cycle, the block terminates the cycle with `is_auto` at 0 and `vector` equal to `data_lo`.
- R5: If an autovector request and `data_ack` are both present at the same edge, the autovector wins.
- R6: For any other `cyc_type` (2'b00 read, 2'b01 write, 2'b10 other), all three acknowledge inputs are ignored. `vec_valid` stays 0 and `vector` and `is_auto` are unchanged.
- R7: While `ext_master` is 1, nothing is terminated. `vec_valid` stays 0 and the outputs are unchanged.
- R8: Each bus cycle gives at most one `vec_valid` pulse, even if acknowledges stay asserted. A new pulse needs `cyc_active` to have been 0 at an edge in between. An autovector request held high therefore autovectors every new interrupt-acknowledge cycle.
- R9: `vector` and `is_auto` hold their values in every cycle in which `vec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_active | input | 1 | A bus cycle is in progress |
| cyc_type | input | 2 | Cycle kind; 2'b11 is interrupt acknowledge |
| ack_level | input | 3 | Interrupt level being acknowledged |
| ext_master | input | 1 | An external master owns the bus |
| avec_pin | input | 1 | Autovector request from the pin, active high |
| cs_avec | input | 1 | Autovector request from chip-select logic |
| data_ack | input | 1 | Normal data acknowledge |
| data_lo | input | 8 | Low byte of the data bus |
| vec_valid | output | 1 | One-cycle strobe: cycle terminated |
| is_auto | output | 1 | The vector was generated internally |
| vector | output | 8 | Vector number to use |

## Verification
A stuck termination flag shows up at the ports as a missing strobe on the very next interrupt-acknowledge cycle. A flag that fails to set shows up as a second strobe one cycle after the first. A wrong source priority or a wrong level offset shows in `is_auto` or `vector` in the cycle right after the sampling edge. A qualifier leak, where a non-acknowledge cycle or an external master is let through, produces a strobe one edge after the stray acknowledge. It is caught before the next stimulus is applied.

// File: rtl/iack_vec_pkg.sv
package iack_vec_pkg;
  localparam int VEC_W     = 8;
  localparam int LVL_W     = 3;
  localparam int AUTO_BASE = 24;

  typedef enum logic [1:0] {
    CK_READ  = 2'b00,
    CK_WRITE = 2'b01,
    CK_OTHER = 2'b10,
    CK_IACK  = 2'b11
  } cyc_kind_e;

  function automatic logic [VEC_W-1:0] auto_number(input logic [LVL_W-1:0] lvl);
    logic [VEC_W-1:0] base;
    base = VEC_W'(AUTO_BASE);
    return base + VEC_W'(lvl);
  endfunction
endpackage

// File: rtl/iack_qualify.sv
module iack_qualify (
  input  logic       cyc_active,
  input  logic [1:0] cyc_type,
  input  logic       ext_master,
  input  logic       busy,
  input  logic       avec_pin,
  input  logic       cs_avec,
  input  logic       data_ack,
  output logic       take_auto,
  output logic       take_data
);
  import iack_vec_pkg::*;

  logic open_iack;

  always_comb begin
    open_iack = cyc_active && (cyc_type == CK_IACK) && !ext_master && !busy;
    take_auto = open_iack && (avec_pin || cs_avec);
    take_data = open_iack && !(avec_pin || cs_avec) && data_ack;
  end
endmodule

// File: rtl/iack_vec_select.sv
module iack_vec_select #(
  parameter int VW = iack_vec_pkg::VEC_W,
  parameter int LW = iack_vec_pkg::LVL_W
) (
  input  logic          use_auto,
  input  logic [LW-1:0] level,
  input  logic [VW-1:0] data_in,
  output logic [VW-1:0] sel_vec
);
  import iack_vec_pkg::*;

  always_comb begin
    sel_vec = use_auto ? auto_number(level) : data_in;
  end
endmodule

// File: rtl/iack_term_ctrl.sv
module iack_term_ctrl #(
  parameter int VW = iack_vec_pkg::VEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_active,
  input  logic          take_auto,
  input  logic          take_data,
  input  logic [VW-1:0] sel_vec,
  output logic          busy,
  output logic          vec_valid,
  output logic          is_auto,
  output logic [VW-1:0] vector
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      vec_valid <= 1'b0;
      is_auto   <= 1'b0;
      vector    <= '0;
    end else begin
      vec_valid <= 1'b0;
      if (!cyc_active) busy <= 1'b0;
      if (take_auto || take_data) begin
        busy      <= 1'b1;
        vec_valid <= 1'b1;
        is_auto   <= take_auto;
        vector    <= sel_vec;
      end
    end
  end
endmodule

// File: rtl/iack_vec_term.sv
module iack_vec_term (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_active,
  input  logic [1:0] cyc_type,
  input  logic [2:0] ack_level,
  input  logic       ext_master,
  input  logic       avec_pin,
  input  logic       cs_avec,
  input  logic       data_ack,
  input  logic [7:0] data_lo,
  output logic       vec_valid,
  output logic       is_auto,
  output logic [7:0] vector
);
  import iack_vec_pkg::*;

  logic             busy;
  logic             take_auto;
  logic             take_data;
  logic [VEC_W-1:0] sel_vec;

  iack_qualify u_qual (
    .cyc_active (cyc_active),
    .cyc_type   (cyc_type),
    .ext_master (ext_master),
    .busy       (busy),
    .avec_pin   (avec_pin),
    .cs_avec    (cs_avec),
    .data_ack   (data_ack),
    .take_auto  (take_auto),
    .take_data  (take_data)
  );

  iack_vec_select #(.VW(VEC_W), .LW(LVL_W)) u_sel (
    .use_auto (take_auto),
    .level    (ack_level),
    .data_in  (data_lo),
    .sel_vec  (sel_vec)
  );

  iack_term_ctrl #(.VW(VEC_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_active (cyc_active),
    .take_auto  (take_auto),
    .take_data  (take_data),
    .sel_vec    (sel_vec),
    .busy       (busy),
    .vec_valid  (vec_valid),
    .is_auto    (is_auto),
    .vector     (vector)
  );
endmodule

// File: rtl/iack_vec_term_chk.sv
module iack_vec_term_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_active,
  input logic [1:0] cyc_type,
  input logic [2:0] ack_level,
  input logic       ext_master,
  input logic       avec_pin,
  input logic       cs_avec,
  input logic       data_ack,
  input logic [7:0] data_lo,
  input logic       vec_valid,
  input logic       is_auto,
  input logic [7:0] vector
);
  import iack_vec_pkg::*;

  p_auto_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && is_auto) |-> (vector == auto_number($past(ack_level))));

  p_data_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !is_auto) |-> (vector == $past(data_lo) && $past(data_ack)));

  p_avec_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && $past(avec_pin || cs_avec)) |-> is_auto);

  p_iack_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(cyc_active) && $past(cyc_type) == CK_IACK));

  p_no_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !$past(ext_master));

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> ($stable(vector) && $stable(is_auto)));
endmodule

bind iack_vec_term iack_vec_term_chk u_chk (.*);

// File: tb/iack_vec_term_test.sv
`timescale 1ns/1ps
module iack_vec_term_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_active, ext_master, avec_pin, cs_avec, data_ack;
  logic [1:0] cyc_type;
  logic [2:0] ack_level;
  logic [7:0] data_lo;
  logic       vec_valid, is_auto;
  logic [7:0] vector;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] last_vec = 8'd0;
  logic       last_auto = 1'b0;

  always #4 clk = ~clk;

  iack_vec_term uut (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic idle();
    cyc_active = 0; cyc_type = 2'b00; ack_level = 0; ext_master = 0;
    avec_pin = 0; cs_avec = 0; data_ack = 0; data_lo = 0;
  endtask

  // one bus cycle held for two edges, then released
  task automatic bus_cycle(input string tag, input logic [1:0] ty, input logic [2:0] lvl,
                           input logic pin, input logic cs, input logic dack,
                           input logic [7:0] dat, input logic ext,
                           input logic exp_term, input logic exp_auto, input logic [7:0] exp_vec);
    @(negedge clk);
    cyc_active = 1; cyc_type = ty; ack_level = lvl; avec_pin = pin; cs_avec = cs;
    data_ack = dack; data_lo = dat; ext_master = ext;
    @(posedge clk); #1;
    if (exp_term) begin last_vec = exp_vec; last_auto = exp_auto; end
    chk({tag, " strobe"}, {7'd0, vec_valid}, {7'd0, exp_term});
    chk({tag, " auto"}, {7'd0, is_auto}, {7'd0, last_auto});
    chk({tag, " vector"}, vector, last_vec);
    @(posedge clk); #1;
    chk({tag, " R8 one strobe"}, {7'd0, vec_valid}, 8'd0);
    chk({tag, " R9 hold"}, vector, last_vec);
    @(negedge clk); idle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 valid", {7'd0, vec_valid}, 8'd0);
    chk("R1 auto", {7'd0, is_auto}, 8'd0);
    chk("R1 vector", vector, 8'd0);
  endtask

  task automatic t_pin_levels();
    for (int l = 0; l < 8; l++)
      bus_cycle("R2 pin", 2'b11, 3'(l), 1, 0, 0, 8'hA5, 0, 1, 1, 8'(24 + l));
  endtask

  task automatic t_cs_auto();
    bus_cycle("R3 cs", 2'b11, 3'd4, 0, 1, 0, 8'h77, 0, 1, 1, 8'd28);
    bus_cycle("R3 cs", 2'b11, 3'd7, 0, 1, 0, 8'h00, 0, 1, 1, 8'd31);
  endtask

  task automatic t_data_vec();
    bus_cycle("R4 data", 2'b11, 3'd3, 0, 0, 1, 8'h40, 0, 1, 0, 8'h40);
    bus_cycle("R4 data", 2'b11, 3'd5, 0, 0, 1, 8'hFF, 0, 1, 0, 8'hFF);
  endtask

  task automatic t_both();
    bus_cycle("R5 both", 2'b11, 3'd2, 1, 0, 1, 8'h99, 0, 1, 1, 8'd26);
    bus_cycle("R5 both", 2'b11, 3'd6, 0, 1, 1, 8'h12, 0, 1, 1, 8'd30);
  endtask

  task automatic t_non_iack();
    bus_cycle("R4 setup", 2'b11, 3'd1, 0, 0, 1, 8'h5C, 0, 1, 0, 8'h5C);
    for (int t = 0; t < 3; t++)
      bus_cycle("R6 ignored", 2'(t), 3'd6, 1, 1, 1, 8'h33, 0, 0, 0, 8'h00);
  endtask

  task automatic t_ext_master();
    bus_cycle("R7 ext", 2'b11, 3'd3, 1, 0, 0, 8'h21, 1, 0, 0, 8'h00);
    bus_cycle("R7 ext", 2'b11, 3'd3, 0, 0, 1, 8'h21, 1, 0, 0, 8'h00);
  endtask

  task automatic t_held_avec();
    @(negedge clk);
    cyc_active = 1; cyc_type = 2'b11; ack_level = 3'd5; avec_pin = 1;
    @(posedge clk); #1;
    chk("R8 first strobe", {7'd0, vec_valid}, 8'd1);
    chk("R8 first vector", vector, 8'd29);
    repeat (3) begin
      @(posedge clk); #1;
      chk("R8 no repeat", {7'd0, vec_valid}, 8'd0);
    end
    @(negedge clk); cyc_active = 0; ack_level = 3'd2;
    @(posedge clk); #1;
    chk("R8 gap", {7'd0, vec_valid}, 8'd0);
    @(negedge clk); cyc_active = 1;
    @(posedge clk); #1;
    chk("R8 new cycle strobe", {7'd0, vec_valid}, 8'd1);
    chk("R8 new cycle vector", vector, 8'd26);
    last_vec = 8'd26; last_auto = 1'b1;
    @(negedge clk); idle();
    @(posedge clk); #1;
  endtask

  bit finished = 0;

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_pin_levels();
    t_cs_auto();
    t_data_vec();
    t_both();
    t_non_iack();
    t_ext_master();
    t_held_avec();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule